// File: doc/BRIEF.md
# Write-Back Data Cache with Line Maintenance Commands

This block is a small direct-mapped write-back data cache that sits between a processor load/store port and a line-wide memory bus. Each line keeps a tag, a valid bit, a dirty bit and sixteen 32-bit words. Ordinary word loads and stores are served from the array. A store marks its line dirty. A miss first writes back a dirty victim, then fetches the new line, then completes the access.

The same request port also takes three commands that act on the one line holding the given address. Invalidate drops the line without writing it back. Clean writes a dirty line to memory and keeps it resident. Flush writes a dirty line back and then drops it. A command aimed at the uncacheable part of the address space does nothing and returns an access fault. A command that misses leaves every line exactly as it was.

The processor presents a request while `req_ready` is high and waits for the one-cycle `rsp_done` pulse. The memory side holds a request until the bus acknowledges it.

Top module: `wbc_cache`

## Requirements
- R1: Reset clears every valid and dirty bit. After reset `req_ready` is 1, `rsp_done` and `mem_req` are 0, and the first access to any line misses.
- R2: A load that hits returns the addressed word, with `rsp_done` high in the cycle after acceptance and no bus transaction. `rsp_done` is never high for two cycles in a row.
- R3: A store writes its word and sets the line dirty. A store hit makes no bus transaction. A store miss fills the line first, and a later load returns the stored word.
- R4: A load or store miss whose victim is valid and dirty writes the victim line back (bus write to the victim's line address) before fetching the new line. A miss with a clean or invalid victim only fetches.
- R5: Invalidate (op code 2) on a hit clears both valid and dirty and never writes data to memory. A later load therefore refetches and sees the memory copy.
- R6: Invalidate on a line that is absent or already invalid changes no line state, raises no fault, makes no bus transaction and completes in the cycle after acceptance.
- R7: Clean (op code 3) on a dirty hit writes the line back and clears dirty while keeping valid, so the line still hits and is later evicted without a writeback.
- R8: Flush (op code 4) on a dirty hit writes the line back and clears valid on the bus acknowledge. Flush on a clean hit clears valid without bus traffic.
- R9: Clean or flush on a clean or absent line completes in the cycle after acceptance with no bus transaction.
- R10: A command changes only the line that holds its address. Lines at other indices keep their data and state.
- R11: A maintenance command (op 2, 3 or 4) whose word address is at or above `UC_BASE` (default 0x8000) returns `rsp_fault`=1 with `rsp_done` in the next cycle and changes no state. Loads (op 0) and stores (op 1) never fault.
- R12: While a writeback or fill is in progress, `req_ready` stays 0.
- R13: `mem_req` stays high with stable `mem_addr` and `mem_we` until `mem_ack`. `mem_addr` is the word address shifted right by 4 (16 words per line, index in the low 3 bits of the line address).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | 0 load, 1 store, 2 invalidate, 3 clean, 4 flush |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load result, valid with rsp_done |
| rsp_fault | output | 1 | Access fault, valid with rsp_done |
| mem_req | output | 1 | Bus transaction request |
| mem_we | output | 1 | 1 write line, 0 read line |
| mem_addr | output | 12 | Line address |
| mem_wline | output | 512 | Line data written |
| mem_rline | input | 512 | Line data read, sampled with mem_ack |
| mem_ack | input | 1 | Bus acknowledge, one cycle |

## Verification
The bench attacks the edge conditions around maintenance commands. It invalidates a line that is not present and then checks that the resident line with the same index still hits; a design that ignored the tag compare would drop it. It invalidates a dirty line and then reloads it; a design that wrote back on invalidate would return the stored word instead of the memory word. It flushes a clean resident line; a design that only acted on dirty lines would keep hitting. It cleans a line and then evicts it; a design that left dirty set would issue a second writeback. Commands to the uncacheable range must fault with no bus traffic. A reset with a dirty line resident must lose that line without writing it back.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_INVAL = 3'd2,
        OP_CLEAN = 3'd3,
        OP_FLUSH = 3'd4
    } wbc_op_e;

    typedef enum logic [1:0] {
        ST_READY,
        ST_WRBACK,
        ST_FILL,
        ST_DONE
    } wbc_state_e;

    function automatic logic is_maint(input logic [2:0] op);
        return (op == OP_INVAL) || (op == OP_CLEAN) || (op == OP_FLUSH);
    endfunction

endpackage

// File: rtl/wbc_addr_dec.sv
module wbc_addr_dec #(
    parameter int          ADDR_W  = 16,
    parameter int          OFF_W   = 4,
    parameter int          IDX_W   = 3,
    parameter logic [ADDR_W-1:0] UC_BASE = 16'h8000
) (
    input  logic [ADDR_W-1:0]             addr,
    output logic [OFF_W-1:0]              word_sel,
    output logic [IDX_W-1:0]              idx,
    output logic [ADDR_W-OFF_W-IDX_W-1:0] tag,
    output logic [ADDR_W-OFF_W-1:0]       line_addr,
    output logic                          uncached
);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    always_comb begin
        word_sel  = addr[OFF_W-1:0];
        idx       = addr[OFF_W +: IDX_W];
        tag       = addr[ADDR_W-1 -: TAG_W];
        line_addr = addr[ADDR_W-1:OFF_W];
        uncached  = (addr >= UC_BASE);
    end
endmodule

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 9,
    parameter int LINE_W    = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              meta_we,
    input  logic              nx_valid,
    input  logic              nx_dirty,
    input  logic [TAG_W-1:0]  nx_tag,
    input  logic              data_we,
    input  logic [LINE_W-1:0] nx_line,
    output logic              cur_valid,
    output logic              cur_dirty,
    output logic [TAG_W-1:0]  cur_tag,
    output logic [LINE_W-1:0] cur_line
);
    typedef struct packed {
        logic [NUM_LINES-1:0]             valid;
        logic [NUM_LINES-1:0]             dirty;
        logic [NUM_LINES-1:0][TAG_W-1:0]  tag;
        logic [NUM_LINES-1:0][LINE_W-1:0] data;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (meta_we) begin
            s_d.valid[idx] = nx_valid;
            s_d.dirty[idx] = nx_dirty;
            s_d.tag[idx]   = nx_tag;
        end
        if (data_we) begin
            s_d.data[idx] = nx_line;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_valid = s_q.valid[idx];
    assign cur_dirty = s_q.dirty[idx];
    assign cur_tag   = s_q.tag[idx];
    assign cur_line  = s_q.data[idx];
endmodule

// File: rtl/wbc_word_merge.sv
module wbc_word_merge #(
    parameter int WORDS  = 16,
    parameter int WORD_W = 32,
    parameter int OFF_W  = 4
) (
    input  logic [WORDS*WORD_W-1:0] in_line,
    input  logic [OFF_W-1:0]        sel,
    input  logic [WORD_W-1:0]       wdata,
    output logic [WORDS*WORD_W-1:0] out_line,
    output logic [WORD_W-1:0]       rd_word
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign out_line[g*WORD_W +: WORD_W] =
            (sel == OFF_W'(g)) ? wdata : in_line[g*WORD_W +: WORD_W];
    end

    assign rd_word = in_line[sel*WORD_W +: WORD_W];
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
    import wbc_pkg::*;
#(
    parameter int          WORD_W     = 32,
    parameter int          ADDR_W     = 16,
    parameter int          LINE_WORDS = 16,
    parameter int          NUM_LINES  = 8,
    parameter logic [ADDR_W-1:0] UC_BASE = 16'h8000,
    localparam int OFF_W   = $clog2(LINE_WORDS),
    localparam int IDX_W   = $clog2(NUM_LINES),
    localparam int LADDR_W = ADDR_W - OFF_W,
    localparam int TAG_W   = LADDR_W - IDX_W,
    localparam int LINE_W  = WORD_W * LINE_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [WORD_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               rsp_done,
    output logic [WORD_W-1:0]  rsp_rdata,
    output logic               rsp_fault,
    output logic               mem_req,
    output logic               mem_we,
    output logic [LADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0]  mem_wline,
    input  logic [LINE_W-1:0]  mem_rline,
    input  logic               mem_ack
);
    typedef struct packed {
        wbc_state_e        state;
        wbc_op_e           op;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
        logic              fault;
    } ctl_t;

    ctl_t c_d, c_q;

    // address currently being worked on
    logic [ADDR_W-1:0]  acc_addr;
    logic [WORD_W-1:0]  acc_wdata;
    logic [OFF_W-1:0]   word_sel;
    logic [IDX_W-1:0]   idx;
    logic [TAG_W-1:0]   tag;
    logic [LADDR_W-1:0] line_addr;
    logic               uncached;

    // line array access
    logic               cur_valid, cur_dirty;
    logic [TAG_W-1:0]   cur_tag;
    logic [LINE_W-1:0]  cur_line;
    logic               meta_we, data_we;
    logic               nx_valid, nx_dirty;
    logic [TAG_W-1:0]   nx_tag;
    logic [LINE_W-1:0]  nx_line;

    // word select / merge
    logic [LINE_W-1:0]  src_line, merged_line;
    logic [WORD_W-1:0]  sel_word;
    logic               hit;

    assign acc_addr  = (c_q.state == ST_READY) ? req_addr  : c_q.addr;
    assign acc_wdata = (c_q.state == ST_READY) ? req_wdata : c_q.wdata;
    assign src_line  = (c_q.state == ST_FILL)  ? mem_rline : cur_line;

    wbc_addr_dec #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .UC_BASE(UC_BASE)
    ) u_dec (
        .addr     (acc_addr),
        .word_sel (word_sel),
        .idx      (idx),
        .tag      (tag),
        .line_addr(line_addr),
        .uncached (uncached)
    );

    wbc_line_store #(
        .NUM_LINES(NUM_LINES),
        .IDX_W    (IDX_W),
        .TAG_W    (TAG_W),
        .LINE_W   (LINE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (idx),
        .meta_we  (meta_we),
        .nx_valid (nx_valid),
        .nx_dirty (nx_dirty),
        .nx_tag   (nx_tag),
        .data_we  (data_we),
        .nx_line  (nx_line),
        .cur_valid(cur_valid),
        .cur_dirty(cur_dirty),
        .cur_tag  (cur_tag),
        .cur_line (cur_line)
    );

    wbc_word_merge #(
        .WORDS (LINE_WORDS),
        .WORD_W(WORD_W),
        .OFF_W (OFF_W)
    ) u_merge (
        .in_line (src_line),
        .sel     (word_sel),
        .wdata   (acc_wdata),
        .out_line(merged_line),
        .rd_word (sel_word)
    );

    assign hit = cur_valid && (cur_tag == tag);

    always_comb begin
        c_d      = c_q;
        meta_we  = 1'b0;
        data_we  = 1'b0;
        nx_valid = cur_valid;
        nx_dirty = cur_dirty;
        nx_tag   = cur_tag;
        nx_line  = merged_line;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = line_addr;

        unique case (c_q.state)
            ST_READY: begin
                if (req_valid) begin
                    c_d.op    = wbc_op_e'(req_op);
                    c_d.addr  = req_addr;
                    c_d.wdata = req_wdata;
                    c_d.fault = 1'b0;
                    c_d.state = ST_DONE;
                    if (is_maint(req_op) && uncached) begin
                        c_d.fault = 1'b1;
                    end else begin
                        case (req_op)
                            OP_LOAD: begin
                                if (hit) c_d.rdata = sel_word;
                                else     c_d.state = (cur_valid && cur_dirty) ? ST_WRBACK : ST_FILL;
                            end
                            OP_STORE: begin
                                if (hit) begin
                                    data_we  = 1'b1;
                                    meta_we  = 1'b1;
                                    nx_dirty = 1'b1;
                                end else begin
                                    c_d.state = (cur_valid && cur_dirty) ? ST_WRBACK : ST_FILL;
                                end
                            end
                            OP_INVAL: begin
                                if (hit) begin
                                    meta_we  = 1'b1;
                                    nx_valid = 1'b0;
                                    nx_dirty = 1'b0;
                                end
                            end
                            OP_CLEAN: begin
                                if (hit && cur_dirty) c_d.state = ST_WRBACK;
                            end
                            OP_FLUSH: begin
                                if (hit && cur_dirty) begin
                                    c_d.state = ST_WRBACK;
                                end else if (hit) begin
                                    meta_we  = 1'b1;
                                    nx_valid = 1'b0;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end

            ST_WRBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {cur_tag, idx};
                if (mem_ack) begin
                    meta_we  = 1'b1;
                    nx_dirty = 1'b0;
                    if (c_q.op == OP_FLUSH) nx_valid = 1'b0;
                    if (c_q.op == OP_LOAD || c_q.op == OP_STORE) c_d.state = ST_FILL;
                    else                                         c_d.state = ST_DONE;
                end
            end

            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    meta_we   = 1'b1;
                    data_we   = 1'b1;
                    nx_valid  = 1'b1;
                    nx_tag    = tag;
                    nx_dirty  = (c_q.op == OP_STORE);
                    nx_line   = (c_q.op == OP_STORE) ? merged_line : mem_rline;
                    c_d.rdata = sel_word;
                    c_d.state = ST_DONE;
                end
            end

            ST_DONE: begin
                c_d.state = ST_READY;
            end

            default: c_d.state = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_READY;
        end else begin
            c_q <= c_d;
        end
    end

    assign mem_wline = cur_line;
    assign req_ready = (c_q.state == ST_READY);
    assign rsp_done  = (c_q.state == ST_DONE);
    assign rsp_rdata = c_q.rdata;
    assign rsp_fault = c_q.fault && (c_q.state == ST_DONE);
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
    parameter int          ADDR_W  = 16,
    parameter int          LADDR_W = 12,
    parameter logic [ADDR_W-1:0] UC_BASE = 16'h8000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [2:0]         req_op,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               req_ready,
    input logic               rsp_done,
    input logic               rsp_fault,
    input logic               mem_req,
    input logic               mem_we,
    input logic [LADDR_W-1:0] mem_addr,
    input logic               mem_ack
);
    logic accepted, maint_op;
    assign accepted = req_valid && req_ready;
    assign maint_op = (req_op == 3'd2) || (req_op == 3'd3) || (req_op == 3'd4);

    p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_uc_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && maint_op && (req_addr >= UC_BASE)) |=> (rsp_done && rsp_fault && !mem_req));

    p_fault_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_done);

    // R5 and R6: invalidate never reaches the bus
    p_inval_no_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && req_op == 3'd2) |=> (rsp_done && !mem_req));

    p_bus_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind wbc_cache wbc_cache_chk #(
    .ADDR_W (ADDR_W),
    .LADDR_W(LADDR_W),
    .UC_BASE(UC_BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_addr (req_addr),
    .req_ready(req_ready),
    .rsp_done (rsp_done),
    .rsp_fault(rsp_fault),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack)
);

// File: tb/wbc_cache_tb.sv
`timescale 1ns/1ps
module wbc_cache_tb;
    localparam int LAT = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [2:0]   req_op = 3'd0;
    logic [15:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         req_ready, rsp_done, rsp_fault;
    logic [31:0]  rsp_rdata;
    logic         mem_req, mem_we;
    logic [11:0]  mem_addr;
    logic [511:0] mem_wline, mem_rline;
    logic         mem_ack = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    wbc_cache u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wline(mem_wline), .mem_rline(mem_rline), .mem_ack(mem_ack)
    );

    // memory model: 64 lines, word w of line L holds A000_0000 | L<<8 | w
    logic [511:0] bmem [64];
    int rd_cnt = 0, wr_cnt = 0, lat = 0;
    logic [11:0] last_wr_addr = '0, last_rd_addr = '0;

    initial begin
        for (int l = 0; l < 64; l++)
            for (int w = 0; w < 16; w++)
                bmem[l][w*32 +: 32] = 32'hA000_0000 | (l << 8) | w;
    end

    assign mem_rline = bmem[mem_addr[5:0]];

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (lat == LAT) begin
                lat     <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    bmem[mem_addr[5:0]] <= mem_wline;
                    wr_cnt       <= wr_cnt + 1;
                    last_wr_addr <= mem_addr;
                end else begin
                    rd_cnt       <= rd_cnt + 1;
                    last_rd_addr <= mem_addr;
                end
            end else begin
                lat <= lat + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic xact(input logic [2:0] op, input logic [15:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic flt, output int cyc,
                        output int nrd, output int nwr, output int rdy);
        int r0, w0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; rdy = 0;
        while (!rsp_done && cyc < 200) begin
            if (req_ready) rdy++;
            @(negedge clk);
            cyc++;
        end
        rd  = rsp_rdata;
        flt = rsp_fault;
        nrd = rd_cnt - r0;
        nwr = wr_cnt - w0;
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] addr;
        logic [31:0] wd;
        logic [31:0] rd;
        logic [1:0]  nrd;
        logic [1:0]  nwr;
        logic        flt;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 16'h0013, 32'h0,        32'hA0000103, 2'd1, 2'd0, 1'b0, 8'd1},  // R1 first access misses
        '{3'd0, 16'h0015, 32'h0,        32'hA0000105, 2'd0, 2'd0, 1'b0, 8'd2},  // R2 load hit
        '{3'd1, 16'h0016, 32'h11112222, 32'h0,        2'd0, 2'd0, 1'b0, 8'd3},  // R3 store hit
        '{3'd0, 16'h0016, 32'h0,        32'h11112222, 2'd0, 2'd0, 1'b0, 8'd3},  // R3 readback
        '{3'd0, 16'h0093, 32'h0,        32'hA0000903, 2'd1, 2'd1, 1'b0, 8'd4},  // R4 dirty victim
        '{3'd0, 16'h0016, 32'h0,        32'h11112222, 2'd1, 2'd0, 1'b0, 8'd4},  // R4 clean victim, data was written
        '{3'd1, 16'h0020, 32'h33334444, 32'h0,        2'd1, 2'd0, 1'b0, 8'd3},  // R3 store miss
        '{3'd2, 16'h0020, 32'h0,        32'h0,        2'd0, 2'd0, 1'b0, 8'd5},  // R5 inval dirty hit
        '{3'd0, 16'h0020, 32'h0,        32'hA0000200, 2'd1, 2'd0, 1'b0, 8'd5},  // R5 dirty data dropped
        '{3'd2, 16'h00A0, 32'h0,        32'h0,        2'd0, 2'd0, 1'b0, 8'd6},  // R6 inval miss
        '{3'd0, 16'h0021, 32'h0,        32'hA0000201, 2'd0, 2'd0, 1'b0, 8'd6},  // R6 line kept
        '{3'd1, 16'h0031, 32'h55556666, 32'h0,        2'd1, 2'd0, 1'b0, 8'd3},
        '{3'd3, 16'h0031, 32'h0,        32'h0,        2'd0, 2'd1, 1'b0, 8'd7},  // R7 clean dirty
        '{3'd0, 16'h0031, 32'h0,        32'h55556666, 2'd0, 2'd0, 1'b0, 8'd7},  // R7 still valid
        '{3'd0, 16'h00B0, 32'h0,        32'hA0000B00, 2'd1, 2'd0, 1'b0, 8'd7},  // R7 dirty cleared
        '{3'd3, 16'h00B0, 32'h0,        32'h0,        2'd0, 2'd0, 1'b0, 8'd9},  // R9 clean on clean
        '{3'd1, 16'h0042, 32'h77778888, 32'h0,        2'd1, 2'd0, 1'b0, 8'd3},
        '{3'd1, 16'h0052, 32'h9999AAAA, 32'h0,        2'd1, 2'd0, 1'b0, 8'd10},
        '{3'd4, 16'h0042, 32'h0,        32'h0,        2'd0, 2'd1, 1'b0, 8'd8},  // R8 flush dirty
        '{3'd0, 16'h0052, 32'h0,        32'h9999AAAA, 2'd0, 2'd0, 1'b0, 8'd10}, // R10 neighbour kept
        '{3'd0, 16'h0042, 32'h0,        32'h77778888, 2'd1, 2'd0, 1'b0, 8'd8},  // R8 invalid, data in memory
        '{3'd4, 16'h0042, 32'h0,        32'h0,        2'd0, 2'd0, 1'b0, 8'd9},  // R9 flush clean
        '{3'd0, 16'h0043, 32'h0,        32'hA0000403, 2'd1, 2'd0, 1'b0, 8'd8},  // R8 clean flush invalidates
        '{3'd4, 16'h0060, 32'h0,        32'h0,        2'd0, 2'd0, 1'b0, 8'd9},  // R9 flush absent
        '{3'd2, 16'h8050, 32'h0,        32'h0,        2'd0, 2'd0, 1'b1, 8'd11}, // R11 uncacheable
        '{3'd4, 16'hC052, 32'h0,        32'h0,        2'd0, 2'd0, 1'b1, 8'd11}, // R11 uncacheable
        '{3'd0, 16'h0052, 32'h0,        32'h9999AAAA, 2'd0, 2'd0, 1'b0, 8'd11}  // R11 no state change
    };

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic flt;
        int cyc, nrd, nwr, rdy;
        string rq;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_done == 1'b0 && mem_req == 1'b0, "R1", "done/mem_req after reset",
            {rsp_done, mem_req}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            xact(VECS[i].op, VECS[i].addr, VECS[i].wd, rd, flt, cyc, nrd, nwr, rdy);
            rq = $sformatf("R%0d", VECS[i].req);
            chk(nrd == int'(VECS[i].nrd), rq, $sformatf("vec %0d bus reads", i),
                64'(nrd), 64'(VECS[i].nrd));
            chk(nwr == int'(VECS[i].nwr), rq, $sformatf("vec %0d bus writes", i),
                64'(nwr), 64'(VECS[i].nwr));
            chk(flt == VECS[i].flt, rq, $sformatf("vec %0d fault", i),
                64'(flt), 64'(VECS[i].flt));
            if (VECS[i].op == 3'd0)
                chk(rd == VECS[i].rd, rq, $sformatf("vec %0d load data", i),
                    64'(rd), 64'(VECS[i].rd));
            if (VECS[i].nrd == 0 && VECS[i].nwr == 0)
                chk(cyc == 1, rq, $sformatf("vec %0d latency", i), 64'(cyc), 64'd1);
        end

        // R4 R12 R13: dirty eviction ordering and addresses
        xact(3'd1, 16'h0070, 32'hDEADBEEF, rd, flt, cyc, nrd, nwr, rdy);
        xact(3'd0, 16'h00F5, 32'h0, rd, flt, cyc, nrd, nwr, rdy);
        chk(rdy == 0, "R12", "ready while busy", 64'(rdy), 64'd0);
        chk(last_wr_addr == 12'h007, "R13", "writeback line address", 64'(last_wr_addr), 64'h7);
        chk(last_rd_addr == 12'h00F, "R13", "fill line address", 64'(last_rd_addr), 64'hF);
        chk(bmem[7][31:0] == 32'hDEADBEEF, "R4", "victim data in memory",
            64'(bmem[7][31:0]), 64'hDEADBEEF);
        chk(rd == 32'hA0000F05, "R4", "load after eviction", 64'(rd), 64'hA0000F05);

        // R1: reset drops dirty line without writeback
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_done == 1'b0 && mem_req == 1'b0, "R1",
            "state after second reset", {req_ready, rsp_done, mem_req}, 64'b100);
        rst_n = 1'b1;
        xact(3'd0, 16'h0052, 32'h0, rd, flt, cyc, nrd, nwr, rdy);
        chk(nrd == 1 && nwr == 0, "R1", "miss after reset (reads,writes)",
            {32'(nrd), 32'(nwr)}, {32'd1, 32'd0});
        chk(rd == 32'hA0000502, "R1", "memory copy after reset", 64'(rd), 64'hA0000502);

        finish_run();
    end
endmodule